// File: doc/BRIEF.md
# Two-Error-Correcting Extended BCH Codec (32-bit word)

This block guards a 32-bit data word with twelve cyclic check bits and one overall parity bit, 45 bits in all. The encoder side is purely combinational. Data goes in and the full codeword comes out in the same cycle, ready to be stored.

The decoder side takes a received 45-bit word and forms a 12-bit remainder syndrome and the overall parity in parallel. A table of per-position syndrome columns then picks out every flipped bit at once, with no iteration. The corrected data and a three-way outcome are captured in an output register.

A user writes `enc_code` to storage. On a read, the stored word is presented on `dec_code`, and the corrected word and status are taken one rising edge later. One or two flipped bits anywhere in the word are repaired. Three flipped bits are always flagged and never silently altered.

Top module: `bch_codec`

## Requirements
- R1: `enc_code[31:0]` equals `enc_data`. Data bit j is the coefficient of x^(12+j), and check bit 32+i is the coefficient of x^i. `enc_code[43:32]` is the remainder of x^12·d(x) divided by g(x) = x^12+x^10+x^8+x^5+x^4+x^3+1. Bit 44 makes the count of ones in all 45 bits even. All of this is combinational.
- R2: A received word equal to a valid codeword gives `dec_data` equal to its bits [31:0], with all three flags low.
- R3: A word with exactly one bit inverted, at any of the 45 positions, gives the original data and raises only `dec_single`.
- R4: A word with exactly two bits inverted, at any two distinct positions, gives the original data and raises only `dec_double`.
- R5: A word with exactly three bits inverted raises only `dec_uncorr`, and never `dec_single` or `dec_double`.
- R6: When `dec_uncorr` is high, `dec_data` equals bits [31:0] of the received word, unchanged.
- R7: Errors confined to bits [44:32] leave `dec_data` equal to the original data and raise the flag for their count (one or two).
- R8: Decoder outputs change only at a rising clock edge and reflect the `dec_code` value present at that edge.
- R9: While `rst_n` is low, `dec_data` and all three flags are zero.
- R10: At most one of `dec_single`, `dec_double`, `dec_uncorr` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder output register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_data | input | 32 | Data word to encode |
| enc_code | output | 45 | Codeword: data, check bits, parity |
| dec_code | input | 45 | Received codeword to decode |
| dec_data | output | 32 | Corrected data, registered |
| dec_single | output | 1 | One bit was corrected |
| dec_double | output | 1 | Two bits were corrected |
| dec_uncorr | output | 1 | Error pattern not correctable |

## Verification
The encoder result is due combinationally, so the bench reads `enc_code` a settle delay after driving `enc_data`. Every decoder result is due exactly one rising edge after the word is applied. The bench drives `dec_code` on a falling edge and samples all outputs on the next falling edge, after the single capturing rising edge. For the latency case it also samples just after driving, before that edge, and expects the outputs of the previous word to persist.

// File: rtl/bch_pkg.sv
package bch_pkg;

    localparam int DATA_W = 32;
    localparam int CHK_W  = 12;
    localparam int BCH_W  = DATA_W + CHK_W;
    localparam int CODE_W = BCH_W + 1;
    localparam int PAR_POS = BCH_W;

    // x^12 + x^10 + x^8 + x^5 + x^4 + x^3 + 1
    localparam logic [CHK_W:0] GEN_POLY = 13'b1_0101_0011_1001;

    // Syndrome column of a codeword position: x^e mod g(x), where data
    // bit j sits at exponent CHK_W+j and check bit CHK_W..: exponent pos-DATA_W.
    function automatic logic [CHK_W-1:0] col_of(input int pos);
        int             e;
        logic [CHK_W:0] r;
        e = (pos < DATA_W) ? pos + CHK_W : pos - DATA_W;
        r = {{CHK_W{1'b0}}, 1'b1};
        for (int k = 0; k < e; k++) begin
            r = r << 1;
            if (r[CHK_W]) begin
                r = r ^ GEN_POLY;
            end
        end
        return r[CHK_W-1:0];
    endfunction

endpackage

// File: rtl/bch_encoder.sv
module bch_encoder
    import bch_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);

    logic [CHK_W-1:0] contrib [DATA_W];
    logic [CHK_W-1:0] chk;

    for (genvar j = 0; j < DATA_W; j++) begin : g_col
        localparam logic [CHK_W-1:0] COL = col_of(j);
        assign contrib[j] = data_i[j] ? COL : '0;
    end

    always_comb begin
        chk = '0;
        for (int j = 0; j < DATA_W; j++) begin
            chk = chk ^ contrib[j];
        end
    end

    assign code_o = {^{chk, data_i}, chk, data_i};

endmodule

// File: rtl/bch_syndrome.sv
module bch_syndrome
    import bch_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [CHK_W-1:0]  syn_o,
    output logic              par_odd_o
);

    logic [CHK_W-1:0] contrib [BCH_W];

    for (genvar b = 0; b < BCH_W; b++) begin : g_col
        localparam logic [CHK_W-1:0] COL = col_of(b);
        assign contrib[b] = code_i[b] ? COL : '0;
    end

    always_comb begin
        syn_o = '0;
        for (int b = 0; b < BCH_W; b++) begin
            syn_o = syn_o ^ contrib[b];
        end
    end

    assign par_odd_o = ^code_i;

endmodule

// File: rtl/bch_locator.sv
module bch_locator
    import bch_pkg::*;
(
    input  logic [CHK_W-1:0]  syn_i,
    input  logic              par_odd_i,
    output logic [CODE_W-1:0] flip_o,
    output logic              single_o,
    output logic              double_o,
    output logic              uncorr_o
);

    logic [BCH_W-1:0] direct_hit;
    logic [BCH_W-1:0] pair_hit;
    logic             syn_zero;
    logic             any_direct;
    logic             any_pair;

    // direct_hit[b]: syndrome is exactly column b.
    // pair_hit[b]: syndrome minus column b is another column j.
    for (genvar b = 0; b < BCH_W; b++) begin : g_pos
        localparam logic [CHK_W-1:0] COLB = col_of(b);
        logic [BCH_W-1:0] row;
        logic [CHK_W-1:0] resid;
        assign resid         = syn_i ^ COLB;
        assign direct_hit[b] = (syn_i == COLB);
        for (genvar j = 0; j < BCH_W; j++) begin : g_partner
            localparam logic [CHK_W-1:0] COLJ = col_of(j);
            if (j == b) begin : g_self
                assign row[j] = 1'b0;
            end else begin : g_other
                assign row[j] = (resid == COLJ);
            end
        end
        assign pair_hit[b] = |row;
        assign flip_o[b]   = par_odd_i ? direct_hit[b] : (direct_hit[b] | pair_hit[b]);
    end

    assign syn_zero   = (syn_i == '0);
    assign any_direct = |direct_hit;
    assign any_pair   = |pair_hit;

    // Parity bit: alone when syndrome is clean and parity odd,
    // or as partner of a single column hit when parity is even.
    assign flip_o[PAR_POS] = par_odd_i ? syn_zero : any_direct;

    always_comb begin
        single_o = 1'b0;
        double_o = 1'b0;
        uncorr_o = 1'b0;
        if (par_odd_i) begin
            if (syn_zero || any_direct) begin
                single_o = 1'b1;
            end else begin
                uncorr_o = 1'b1;
            end
        end else if (!syn_zero) begin
            if (any_direct || any_pair) begin
                double_o = 1'b1;
            end else begin
                uncorr_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bch_codec.sv
module bch_codec
    import bch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       enc_data,
    output logic [44:0]       enc_code,
    input  logic [44:0]       dec_code,
    output logic [31:0]       dec_data,
    output logic              dec_single,
    output logic              dec_double,
    output logic              dec_uncorr
);

    logic [CHK_W-1:0]  syn;
    logic              par_odd;
    logic [CODE_W-1:0] flip;
    logic              err_single;
    logic              err_double;
    logic              err_uncorr;
    logic [DATA_W-1:0] fixed_data;

    bch_encoder u_enc (
        .data_i (enc_data),
        .code_o (enc_code)
    );

    bch_syndrome u_syn (
        .code_i    (dec_code),
        .syn_o     (syn),
        .par_odd_o (par_odd)
    );

    bch_locator u_loc (
        .syn_i     (syn),
        .par_odd_i (par_odd),
        .flip_o    (flip),
        .single_o  (err_single),
        .double_o  (err_double),
        .uncorr_o  (err_uncorr)
    );

    assign fixed_data = dec_code[DATA_W-1:0] ^ flip[DATA_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_data   <= '0;
            dec_single <= 1'b0;
            dec_double <= 1'b0;
            dec_uncorr <= 1'b0;
        end else begin
            dec_data   <= fixed_data;
            dec_single <= err_single;
            dec_double <= err_double;
            dec_uncorr <= err_uncorr;
        end
    end

    AST_FLAG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dec_single, dec_double, dec_uncorr})); // R10

    AST_CLEAN_NO_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_odd && syn == '0) |-> (flip == '0)); // R2

    AST_SINGLE_ONE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        err_single |-> ($countones(flip) == 1)); // R3

    AST_DOUBLE_TWO_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        err_double |-> ($countones(flip) == 2)); // R4

    AST_UNCORR_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        dec_uncorr |-> (dec_data == $past(dec_code[DATA_W-1:0]))); // R6

endmodule

// File: tb/bch_codec_test.sv
module bch_codec_test;

    localparam logic [12:0] GEN = 13'b1_0101_0011_1001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] enc_data = '0;
    logic [44:0] enc_code;
    logic [44:0] dec_code = '0;
    logic [31:0] dec_data;
    logic        dec_single;
    logic        dec_double;
    logic        dec_uncorr;

    int compared = 0;
    int mismatched = 0;
    bit reported = 0;

    bch_codec uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enc_data   (enc_data),
        .enc_code   (enc_code),
        .dec_code   (dec_code),
        .dec_data   (dec_data),
        .dec_single (dec_single),
        .dec_double (dec_double),
        .dec_uncorr (dec_uncorr)
    );

    always #5 clk = ~clk;

    function automatic logic [44:0] ref_encode(input logic [31:0] d);
        logic [43:0] v;
        v = {d, 12'b0};
        for (int k = 43; k >= 12; k--) begin
            if (v[k]) v = v ^ (44'(GEN) << (k - 12));
        end
        return {^{v[11:0], d}, v[11:0], d};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report;
        if (!reported) begin
            reported = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        end
    endtask

    // apply a received word, sample after the single capturing edge
    task automatic decode(input logic [44:0] cw, input logic [31:0] exp_d,
                          input logic [2:0] exp_f, input string req);
        @(negedge clk);
        dec_code = cw;
        @(negedge clk);
        check(req, {29'b0, dec_single, dec_double, dec_uncorr, dec_data}, {29'b0, exp_f, exp_d});
    endtask

    logic [31:0] words [5] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hA5C3_0F96,
                               32'h1234_5678, 32'h8000_0001};

    task automatic test_reset;
        #1;
        check("R9 reset", {28'b0, dec_single, dec_double, dec_uncorr, dec_data}, '0);
    endtask

    task automatic test_encoder;
        for (int w = 0; w < 5; w++) begin
            enc_data = words[w];
            #1;
            check("R1 encode", 64'(enc_code), 64'(ref_encode(words[w])));
        end
    endtask

    task automatic test_clean;
        for (int w = 0; w < 5; w++) begin
            decode(ref_encode(words[w]), words[w], 3'b000, "R2 clean");
        end
    endtask

    task automatic test_single;
        for (int w = 0; w < 3; w++) begin
            for (int p = 0; p < 45; p++) begin
                logic [44:0] cw = ref_encode(words[w]);
                cw[p] = ~cw[p];
                decode(cw, words[w], 3'b100, p >= 32 ? "R7 single check-bit" : "R3 single");
            end
        end
    endtask

    task automatic test_double;
        for (int w = 2; w < 4; w++) begin
            for (int a = 0; a < 45; a++) begin
                for (int b = a + 1; b < 45; b++) begin
                    logic [44:0] cw = ref_encode(words[w]);
                    cw[a] = ~cw[a];
                    cw[b] = ~cw[b];
                    decode(cw, words[w], 3'b010, a >= 32 ? "R7 double check-bit" : "R4 double");
                end
            end
        end
    endtask

    task automatic test_triple;
        for (int a = 0; a < 45; a++) begin
            for (int b = a + 1; b < 45; b++) begin
                for (int c = b + 1; c < 45; c++) begin
                    logic [44:0] cw = ref_encode(words[2]);
                    cw[a] = ~cw[a];
                    cw[b] = ~cw[b];
                    cw[c] = ~cw[c];
                    // R5 flag, R6 raw data passed through
                    decode(cw, cw[31:0], 3'b001, "R5/R6 triple");
                end
            end
        end
    endtask

    task automatic test_latency;
        logic [44:0] cw_a = ref_encode(words[3]);
        logic [44:0] cw_b = ref_encode(words[4]);
        cw_b[7] = ~cw_b[7];
        decode(cw_a, words[3], 3'b000, "R8 first word");
        @(negedge clk);
        dec_code = cw_b;
        #1;
        check("R8 hold before edge", {29'b0, dec_single, dec_double, dec_uncorr, dec_data},
              {29'b0, 3'b000, words[3]});
        @(posedge clk);
        #1;
        check("R8 update after edge", {29'b0, dec_single, dec_double, dec_uncorr, dec_data},
              {29'b0, 3'b100, words[4]});
    endtask

    initial begin
        test_reset();
        test_encoder();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_clean();
        test_single();
        test_double();
        test_triple();
        test_latency();
        report();
        $finish;
    end

    initial begin
        #(200000 * 10);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

endmodule